// File: doc/BRIEF.md
# Transmit Clock Loss Monitor

The block watches one of three candidate transmit-side clocks and reports when that clock has stopped. It measures against a free-running reference clock. A divide-by-ten counter on the reference clock marks the end of each ten-cycle window with a strobe. Rising edges of the monitored clock are brought into the reference domain by toggle synchronisation. At each strobe the block decides whether the closing window held at least one such edge. If it did, the loss flag clears. If it did not, the loss flag sets. A driver-disable output follows the flag, so that the line drivers float and send no data while the clock is missing.

The clock being watched depends on the datapath configuration. When the jitter attenuator sits in the transmit path, the smoothed clock from the attenuator is watched. In every other placement the block watches the recovered receive clock if remote loopback is active, and the plain transmit clock otherwise. Each candidate clock has its own toggle flop and synchroniser. The selection is made on the synchronised edge pulses in the reference domain, so no clock is ever multiplexed.

Top module: `tx_clock_loss_monitor`

## Requirements
- R1: A strobe closes a window on every tenth rising edge of `ref_clk`. The first strobe falls on the tenth edge after `rst` is released. `clk_lost` may change only at a strobe edge, never on the nine edges before it.
- R2: If the selected clock produced at least one rising edge during the closing window, `clk_lost` is 0 after the strobe edge.
- R3: If the selected clock produced no rising edge during the closing window, `clk_lost` is 1 after the strobe edge.
- R4: Between strobes `clk_lost` holds the value set at the last strobe.
- R5: `drv_hiz` is 1 exactly when `clk_lost` is 1.
- R6: With `ja_sel` = 2'b01 (attenuator in the transmit path), `smooth_clk` is watched whatever `lb_sel` is. Activity on `tx_clk` and `rec_clk` does not clear the flag.
- R7: With `ja_sel` not 2'b01 and `lb_sel` = 2'b10 (remote loopback), `rec_clk` is watched. `tx_clk` and `smooth_clk` are ignored.
- R8: In every other combination of `ja_sel` and `lb_sel`, `tx_clk` is watched.
- R9: Synchronous reset clears `clk_lost` and `drv_hiz` and restarts the strobe count from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock; all decision logic runs on it |
| rst | input | 1 | Synchronous active-high reset |
| ja_sel | input | 2 | Jitter attenuator placement: 00 bypass, 01 transmit path, 10 receive path, 11 test |
| lb_sel | input | 2 | Loopback mode: 00 none, 01 digital local, 10 remote, 11 local |
| smooth_clk | input | 1 | Smoothed clock from the jitter attenuator |
| tx_clk | input | 1 | Transmit clock from the terminal side |
| rec_clk | input | 1 | Recovered receive clock used during remote loopback |
| clk_lost | output | 1 | Loss-of-clock flag, updated at each window strobe |
| drv_hiz | output | 1 | Line driver disable: 1 puts the line outputs in high impedance |

## Verification
Two functions can fall in the same reference cycle: the window decision at the strobe, and the arrival of a synchronised edge pulse, from either a stopped clock's final toggle or a clock that has just been selected. Such a pulse is counted in the window that the strobe closes. The bench provokes this by changing clock enables and the `ja_sel`/`lb_sel` selection at every window boundary, both in directed steps and from a seeded random stream. For each window it works out which source is selected and whether that source ran in the current and previous windows. It expects a clear flag when the source ran in the window and a set flag when the source was silent in both windows. It skips only the window right after a stop, where a late pulse may legitimately land on either side.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;

    localparam int NUM_SRC = 3;

    typedef enum logic [1:0] {
        JA_BYPASS = 2'b00,
        JA_IN_TX  = 2'b01,
        JA_IN_RX  = 2'b10,
        JA_TEST   = 2'b11
    } ja_place_e;

    typedef enum logic [1:0] {
        LB_OFF     = 2'b00,
        LB_DIGITAL = 2'b01,
        LB_REMOTE  = 2'b10,
        LB_LOCAL   = 2'b11
    } lb_mode_e;

    typedef enum logic [1:0] {
        SRC_SMOOTH = 2'd0,
        SRC_TX     = 2'd1,
        SRC_REC    = 2'd2
    } src_e;

    typedef struct packed {
        logic seen;
        logic loss;
    } win_state_t;

    // Priority: attenuator in transmit path, then remote loopback, then plain transmit clock
    function automatic src_e pick_src(ja_place_e ja, lb_mode_e lb);
        if (ja == JA_IN_TX)
            return SRC_SMOOTH;
        else if (lb == LB_REMOTE)
            return SRC_REC;
        else
            return SRC_TX;
    endfunction

endpackage

// File: rtl/clkmon_strobe_gen.sv
module clkmon_strobe_gen #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst,
    output logic strobe
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign strobe = (cnt == LAST);

    generate
        if (DIV > 1) begin : g_chk
            // R1
            strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
                strobe |=> !strobe);
            // R1
            strobe_wrap_chk: assert property (@(posedge clk) disable iff (rst)
                strobe |=> (cnt == '0));
        end
    endgenerate

endmodule

// File: rtl/clkmon_edge_sync.sv
module clkmon_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst,
    input  logic ref_clk,
    output logic edge_pulse
);
    localparam int NS = (STAGES < 2) ? 2 : STAGES;

    // Toggle in the monitored domain: one level change per rising edge
    logic tgl;
    always_ff @(posedge mon_clk) begin
        if (rst)
            tgl <= 1'b0;
        else
            tgl <= ~tgl;
    end

    // Synchroniser and history flop: left unreset so a reset with the clock
    // stopped cannot fabricate an edge
    logic [NS-1:0] sync_q;
    logic          hist_q;
    always_ff @(posedge ref_clk) begin
        sync_q <= {sync_q[NS-2:0], tgl};
        hist_q <= sync_q[NS-1];
    end

    assign edge_pulse = sync_q[NS-1] ^ hist_q;

endmodule

// File: rtl/clkmon_window_judge.sv
module clkmon_window_judge
    import clkmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe,
    input  logic edge_in,
    output logic loss
);
    win_state_t st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else if (strobe) begin
            // An edge arriving in the strobe cycle belongs to the closing window
            st.loss <= ~(st.seen | edge_in);
            st.seen <= 1'b0;
        end else begin
            st.seen <= st.seen | edge_in;
        end
    end

    assign loss = st.loss;

    // R2
    clear_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && (st.seen || edge_in)) |=> !loss);
    // R3
    set_on_silence_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !st.seen && !edge_in) |=> loss);
    // R4
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> $stable(loss));
    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !loss);

endmodule

// File: rtl/tx_clock_loss_monitor.sv
module tx_clock_loss_monitor
    import clkmon_pkg::*;
#(
    parameter int DIV         = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic       ref_clk,
    input  logic       rst,
    input  logic [1:0] ja_sel,
    input  logic [1:0] lb_sel,
    input  logic       smooth_clk,
    input  logic       tx_clk,
    input  logic       rec_clk,
    output logic       clk_lost,
    output logic       drv_hiz
);
    logic [NUM_SRC-1:0] mon_clk_v;
    logic [NUM_SRC-1:0] edge_v;
    logic               strobe;
    logic               sel_edge;
    src_e               sel;

    assign mon_clk_v[int'(SRC_SMOOTH)] = smooth_clk;
    assign mon_clk_v[int'(SRC_TX)]     = tx_clk;
    assign mon_clk_v[int'(SRC_REC)]    = rec_clk;

    generate
        for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
            clkmon_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .mon_clk    (mon_clk_v[i]),
                .rst        (rst),
                .ref_clk    (ref_clk),
                .edge_pulse (edge_v[i])
            );
        end
    endgenerate

    always_comb begin
        sel = pick_src(ja_place_e'(ja_sel), lb_mode_e'(lb_sel));
        case (sel)
            SRC_SMOOTH: sel_edge = edge_v[int'(SRC_SMOOTH)];
            SRC_REC:    sel_edge = edge_v[int'(SRC_REC)];
            default:    sel_edge = edge_v[int'(SRC_TX)];
        endcase
    end

    clkmon_strobe_gen #(.DIV(DIV)) u_strobe (
        .clk    (ref_clk),
        .rst    (rst),
        .strobe (strobe)
    );

    clkmon_window_judge u_judge (
        .clk     (ref_clk),
        .rst     (rst),
        .strobe  (strobe),
        .edge_in (sel_edge),
        .loss    (clk_lost)
    );

    assign drv_hiz = clk_lost;

endmodule

// File: tb/tb_tx_clock_loss_monitor.sv
`timescale 1ns/1ps
module tb_tx_clock_loss_monitor;

    logic       ref_clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] ja_sel = 2'b00;
    logic [1:0] lb_sel = 2'b00;
    logic       smooth_clk = 1'b0;
    logic       tx_clk = 1'b0;
    logic       rec_clk = 1'b0;
    logic       en_s = 1'b1;
    logic       en_t = 1'b1;
    logic       en_r = 1'b1;
    logic       clk_lost;
    logic       drv_hiz;

    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 0;
    logic prev_loss = 1'b0;
    bit [2:0] ran_prev = 3'b111;   // bit0 smooth, bit1 tx, bit2 rec

    tx_clock_loss_monitor dut (
        .ref_clk    (ref_clk),
        .rst        (rst),
        .ja_sel     (ja_sel),
        .lb_sel     (lb_sel),
        .smooth_clk (smooth_clk),
        .tx_clk     (tx_clk),
        .rec_clk    (rec_clk),
        .clk_lost   (clk_lost),
        .drv_hiz    (drv_hiz)
    );

    // 200 MHz reference
    always #2.5 ref_clk = ~ref_clk;

    // Gated monitored clocks with unrelated periods
    initial forever begin #5; if (en_s) smooth_clk = ~smooth_clk; end
    initial forever begin #7; if (en_t) tx_clk = ~tx_clk; end
    initial forever begin #8; if (en_r) rec_clk = ~rec_clk; end

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // 0 smooth, 1 tx, 2 rec
    function automatic int exp_src(input logic [1:0] ja, input logic [1:0] lb);
        if (ja == 2'b01)      return 0;
        else if (lb == 2'b10) return 2;
        else                  return 1;
    endfunction

    function automatic string src_tag(input int s);
        if (s == 0)      return "R6";
        else if (s == 2) return "R7";
        else             return "R8";
    endfunction

    // Called at the negedge just before a window's first reference edge
    task automatic run_window(input logic [1:0] ja, input logic [1:0] lb,
                              input bit es, input bit et, input bit er);
        bit [2:0] now_run;
        int       s;
        string    tag;
        ja_sel = ja; lb_sel = lb; en_s = es; en_t = et; en_r = er;
        now_run = {er, et, es};
        s = exp_src(ja, lb);
        tag = src_tag(s);
        repeat (5) @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R4 hold mid-window", clk_lost, prev_loss);
        chk("R5 driver disable follows flag", drv_hiz, clk_lost);
        repeat (4) @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R1 no update before tenth edge", clk_lost, prev_loss);
        @(posedge ref_clk);
        @(negedge ref_clk);
        if (now_run[s])
            chk({tag, "/R2 selected clock present"}, clk_lost, 1'b0);
        else if (!ran_prev[s])
            chk({tag, "/R3 selected clock absent"}, clk_lost, 1'b1);
        chk("R5 driver disable at strobe", drv_hiz, clk_lost);
        prev_loss = clk_lost;
        ran_prev = now_run;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] rja;
        logic [1:0] rlb;
        bit   [2:0] ren;
        void'($urandom(32'd7741));
        repeat (8) @(posedge ref_clk);
        @(negedge ref_clk);
        // R9: reset state
        chk("R9 flag after reset", clk_lost, 1'b0);
        chk("R9 driver disable after reset", drv_hiz, 1'b0);
        rst = 1'b0;

        // Directed: R8 transmit clock present, then absent
        run_window(2'b00, 2'b00, 1, 1, 1);
        run_window(2'b00, 2'b00, 0, 0, 0);
        run_window(2'b00, 2'b00, 0, 0, 0);
        // R6: smoothed clock chosen even with remote loopback
        run_window(2'b01, 2'b10, 1, 0, 0);
        run_window(2'b01, 2'b10, 0, 1, 1);
        run_window(2'b01, 2'b10, 0, 1, 1);
        // R7: recovered clock under remote loopback
        run_window(2'b10, 2'b10, 0, 1, 1);
        run_window(2'b10, 2'b10, 0, 1, 0);
        run_window(2'b10, 2'b10, 0, 1, 0);
        // R8: test placement with local loopback watches transmit clock
        run_window(2'b11, 2'b11, 0, 1, 0);

        // Random configurations and clock activity
        for (int i = 0; i < 60; i++) begin
            rja = 2'($urandom_range(0, 3));
            rlb = 2'($urandom_range(0, 3));
            ren = 3'($urandom_range(0, 7));
            run_window(rja, rlb, ren[0], ren[1], ren[2]);
        end

        // R9: reset while flagged restarts the strobe count
        run_window(2'b00, 2'b00, 0, 0, 0);
        run_window(2'b00, 2'b00, 0, 0, 0);
        chk("R3 flag set before mid-run reset", clk_lost, 1'b1);
        rst = 1'b1;
        repeat (3) @(posedge ref_clk);
        @(negedge ref_clk);
        chk("R9 flag cleared by reset", clk_lost, 1'b0);
        chk("R9 driver enabled by reset", drv_hiz, 1'b0);
        rst = 1'b0;
        prev_loss = 1'b0;
        ran_prev = 3'b000;
        run_window(2'b00, 2'b00, 0, 0, 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule